// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This block is the synchronous controller that sits beside an SRAM array with a nonvolatile shadow copy. It decides when the array is saved to the shadow and when the shadow is loaded back. It also gates host reads and writes while a transfer is pending or running, and it drives a busy indication toward the system. A save can be started in three ways: a software command, an external hardware request line, or the loss of supply while automatic saving is enabled. A load can be started by a software command or by the return of supply after an outage.

The block keeps a dirty flag that records whether any write was accepted since the last completed save or load. A hardware-requested save or a supply-loss save runs only if this flag is set. A software save always runs. Every request first opens a grace window of `T_DELAY` cycles: reads still pass but new writes are refused. After the window the transfer starts. A load is issued to the array as a clear strobe followed by a load strobe. All durations are parameters counted in clock cycles.

The controller has these states:
- **IDLE**: open for reads and writes.
- **GRACE**: grace window.
- **SAVE_GO**: one cycle carrying the save strobe.
- **SAVE**: the save duration.
- **CLR**: one cycle carrying the clear strobe.
- **LOAD**: one cycle carrying the load strobe.
- **FILL**: the load duration.
- **HOLD**: access blocked until the hardware request is released.
- **DOWN**: supply absent.

The transitions are:
- IDLE→GRACE: on a software command, a dirty hardware request, or a dirty supply loss while automatic saving is on.
- IDLE→HOLD: on a clean hardware request.
- IDLE→DOWN: on a supply loss that does not save.
- GRACE→SAVE_GO or GRACE→CLR: when the window expires; the first for a save, the second for a load.
- SAVE_GO→SAVE, CLR→LOAD, LOAD→FILL: always after one cycle.
- SAVE→DOWN, SAVE→HOLD or SAVE→IDLE: when the save duration expires.
- FILL→DOWN or FILL→IDLE: when the load duration expires.
- HOLD→IDLE: on release of the hardware request.
- HOLD→DOWN: on supply loss.
- DOWN→CLR: on supply return.

Top module: `nv_xfer_seq`

## Requirements
- R1: After reset the controller is in IDLE: `busy_o`, `inhibit_o`, `save_o`, `clear_o` and `load_o` are 0. A write strobe passes to `wr_pass_o`, and automatic saving is enabled.
- R2: A software save runs whether the dirty flag is set or not. `busy_o` is high for `T_DELAY+1+T_STORE` cycles. `save_o` pulses for one cycle exactly `T_DELAY` cycles after the command is sampled.
- R3: During the grace window `busy_o` is 1 and `inhibit_o` is 0. Reads pass (`rd_pass_o` follows `acc_rd_i`) and writes are refused (`wr_pass_o`=0).
- R4: A hardware request with the dirty flag set runs one save (busy `T_DELAY+1+T_STORE` cycles). After the save, `inhibit_o` stays high with `busy_o` low until `hw_req_i` returns to 0.
- R5: A hardware request with the dirty flag clear produces no save and no busy. `inhibit_o` is high from the cycle after the request is sampled until the cycle the release is sampled.
- R6: Any accepted write sets the dirty flag. Completion of any save or load clears it.
- R7: A software load runs a grace window, then one cycle with `clear_o`, then one cycle with `load_o`, then `T_RECALL` fill cycles. Busy totals `T_DELAY+2+T_RECALL` cycles.
- R8: Supply loss with the dirty flag set and automatic saving enabled runs a save and then enters DOWN. Supply loss that is clean, or that occurs with automatic saving disabled, enters DOWN with no save.
- R9: While `pwr_ok_i` is 0 no read or write passes. On supply return a load runs: clear, load, then `T_HRECALL` fill cycles, with `busy_o` high throughout.
- R10: The commands `as_dis_i` and `as_en_i` turn automatic saving off and on. They are taken only in IDLE; disable wins when both are present.
- R11: A supply loss and a hardware request arriving in the same cycle with the dirty flag set produce exactly one save.
- R12: At most one of `save_o`, `clear_o`, `load_o` is high at a time. While busy, no write passes and software commands are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| acc_rd_i | input | 1 | Host read strobe |
| acc_wr_i | input | 1 | Host write strobe |
| hw_req_i | input | 1 | External save request, active high |
| pwr_ok_i | input | 1 | Supply above switch threshold |
| sw_store_i | input | 1 | Software save command pulse |
| sw_recall_i | input | 1 | Software load command pulse |
| as_en_i | input | 1 | Enable automatic save on supply loss |
| as_dis_i | input | 1 | Disable automatic save on supply loss |
| rd_pass_o | output | 1 | Read accepted toward the array |
| wr_pass_o | output | 1 | Write accepted toward the array |
| busy_o | output | 1 | Transfer pending or running |
| inhibit_o | output | 1 | All access blocked |
| save_o | output | 1 | One-cycle save strobe to the array |
| clear_o | output | 1 | One-cycle array clear strobe |
| load_o | output | 1 | One-cycle shadow load strobe |

## Verification
The assertions check several rules on every cycle:
- writes are refused while busy and all access is refused while the supply is low;
- the three array strobes never overlap;
- a clear strobe is always followed by a load strobe;
- a blocked, non-busy hold persists while the request and supply stay high.

The bench scenarios show what single cycles cannot. Examples are whether a save is skipped because the dirty flag is clear, the exact busy and inhibit lengths for each trigger, the merging of simultaneous triggers, and the effect of the automatic-save commands.

// File: rtl/nv_seq_pkg.sv
package nv_seq_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_GRACE,
        S_SAVE_GO,
        S_SAVE,
        S_CLR,
        S_LOAD,
        S_FILL,
        S_HOLD,
        S_DOWN
    } seq_st_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/nv_dirty_flag.sv
module nv_dirty_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic dirty_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      dirty_o <= 1'b0;
        else if (clr_i)  dirty_o <= 1'b0;
        else if (set_i)  dirty_o <= 1'b1;
    end
endmodule

// File: rtl/nv_dur_timer.sv
module nv_dur_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_i,
    input  logic [CW-1:0] ld_val_i,
    output logic          zero_o
);
    logic [CW-1:0] cnt_q;

    assign zero_o = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (ld_i)    cnt_q <= ld_val_i;
        else if (!zero_o) cnt_q <= cnt_q - 1'b1;
    end
endmodule

// File: rtl/nv_seq_ctrl.sv
module nv_seq_ctrl
    import nv_seq_pkg::*;
#(
    parameter int T_DELAY   = 3,
    parameter int T_STORE   = 5,
    parameter int T_RECALL  = 4,
    parameter int T_HRECALL = 6,
    parameter int CW        = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_ok_i,
    input  logic          hw_req_i,
    input  logic          sw_store_i,
    input  logic          sw_recall_i,
    input  logic          as_en_i,
    input  logic          as_dis_i,
    input  logic          dirty_i,
    input  logic          tmr_zero_i,
    output logic          tmr_ld_o,
    output logic [CW-1:0] tmr_val_o,
    output logic          fin_o,
    output logic          busy_o,
    output logic          inhibit_o,
    output logic          rd_ok_o,
    output logic          wr_ok_o,
    output logic          save_o,
    output logic          clear_o,
    output logic          load_o
);
    seq_st_t st_q, st_d;
    logic    op_rcl_q, op_rcl_d;
    logic    pwrup_q, pwrup_d;
    logic    auto_q, auto_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= S_IDLE;
            op_rcl_q <= 1'b0;
            pwrup_q  <= 1'b0;
            auto_q   <= 1'b1;
        end else begin
            st_q     <= st_d;
            op_rcl_q <= op_rcl_d;
            pwrup_q  <= pwrup_d;
            auto_q   <= auto_d;
        end
    end

    // next state and timer load
    always_comb begin
        st_d      = st_q;
        op_rcl_d  = op_rcl_q;
        pwrup_d   = pwrup_q;
        auto_d    = auto_q;
        fin_o     = 1'b0;
        tmr_ld_o  = 1'b0;
        tmr_val_o = '0;
        unique case (st_q)
            S_IDLE: begin
                if (!pwr_ok_i) begin
                    op_rcl_d = 1'b0;
                    st_d     = (auto_q && dirty_i) ? S_GRACE : S_DOWN;
                end else if (hw_req_i) begin
                    op_rcl_d = 1'b0;
                    st_d     = dirty_i ? S_GRACE : S_HOLD;
                end else if (sw_store_i) begin
                    op_rcl_d = 1'b0;
                    st_d     = S_GRACE;
                end else if (sw_recall_i) begin
                    op_rcl_d = 1'b1;
                    pwrup_d  = 1'b0;
                    st_d     = S_GRACE;
                end else if (as_dis_i) begin
                    auto_d = 1'b0;
                end else if (as_en_i) begin
                    auto_d = 1'b1;
                end
            end
            S_GRACE:   if (tmr_zero_i) st_d = op_rcl_q ? S_CLR : S_SAVE_GO;
            S_SAVE_GO: st_d = S_SAVE;
            S_SAVE: begin
                if (tmr_zero_i) begin
                    fin_o = 1'b1;
                    if (!pwr_ok_i)     st_d = S_DOWN;
                    else if (hw_req_i) st_d = S_HOLD;
                    else               st_d = S_IDLE;
                end
            end
            S_CLR:  st_d = S_LOAD;
            S_LOAD: st_d = S_FILL;
            S_FILL: begin
                if (tmr_zero_i) begin
                    fin_o   = 1'b1;
                    pwrup_d = 1'b0;
                    st_d    = pwr_ok_i ? S_IDLE : S_DOWN;
                end
            end
            S_HOLD: begin
                if (!pwr_ok_i)     st_d = S_DOWN;
                else if (!hw_req_i) st_d = S_IDLE;
            end
            S_DOWN: begin
                if (pwr_ok_i) begin
                    pwrup_d = 1'b1;
                    st_d    = S_CLR;
                end
            end
            default: st_d = S_IDLE;
        endcase
        if (st_d != st_q) begin
            case (st_d)
                S_GRACE: begin tmr_ld_o = 1'b1; tmr_val_o = CW'(T_DELAY - 1); end
                S_SAVE:  begin tmr_ld_o = 1'b1; tmr_val_o = CW'(T_STORE - 1); end
                S_FILL:  begin
                    tmr_ld_o  = 1'b1;
                    tmr_val_o = pwrup_d ? CW'(T_HRECALL - 1) : CW'(T_RECALL - 1);
                end
                default: tmr_ld_o = 1'b0;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy_o    = 1'b0;
        inhibit_o = 1'b1;
        rd_ok_o   = 1'b0;
        wr_ok_o   = 1'b0;
        save_o    = 1'b0;
        clear_o   = 1'b0;
        load_o    = 1'b0;
        unique case (st_q)
            S_IDLE:    begin inhibit_o = 1'b0; rd_ok_o = 1'b1; wr_ok_o = 1'b1; end
            S_GRACE:   begin inhibit_o = 1'b0; rd_ok_o = 1'b1; busy_o = 1'b1; end
            S_SAVE_GO: begin busy_o = 1'b1; save_o = 1'b1; end
            S_SAVE:    busy_o = 1'b1;
            S_CLR:     begin busy_o = 1'b1; clear_o = 1'b1; end
            S_LOAD:    begin busy_o = 1'b1; load_o = 1'b1; end
            S_FILL:    busy_o = 1'b1;
            S_HOLD:    busy_o = 1'b0;
            S_DOWN:    busy_o = 1'b0;
            default:   busy_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/nv_xfer_seq.sv
module nv_xfer_seq #(
    parameter int T_DELAY   = 3,
    parameter int T_STORE   = 5,
    parameter int T_RECALL  = 4,
    parameter int T_HRECALL = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic acc_rd_i,
    input  logic acc_wr_i,
    input  logic hw_req_i,
    input  logic pwr_ok_i,
    input  logic sw_store_i,
    input  logic sw_recall_i,
    input  logic as_en_i,
    input  logic as_dis_i,
    output logic rd_pass_o,
    output logic wr_pass_o,
    output logic busy_o,
    output logic inhibit_o,
    output logic save_o,
    output logic clear_o,
    output logic load_o
);
    localparam int MAXD = nv_seq_pkg::max2(nv_seq_pkg::max2(T_DELAY, T_STORE),
                                           nv_seq_pkg::max2(T_RECALL, T_HRECALL));
    localparam int CW   = $clog2(MAXD + 1);

    logic          dirty, tmr_zero, tmr_ld, fin, rd_ok, wr_ok;
    logic [CW-1:0] tmr_val;

    assign rd_pass_o = acc_rd_i & rd_ok & pwr_ok_i;
    assign wr_pass_o = acc_wr_i & wr_ok & pwr_ok_i;

    nv_dirty_flag u_dirty (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (wr_pass_o),
        .clr_i   (fin),
        .dirty_o (dirty)
    );

    nv_dur_timer #(.CW(CW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_i     (tmr_ld),
        .ld_val_i (tmr_val),
        .zero_o   (tmr_zero)
    );

    nv_seq_ctrl #(
        .T_DELAY   (T_DELAY),
        .T_STORE   (T_STORE),
        .T_RECALL  (T_RECALL),
        .T_HRECALL (T_HRECALL),
        .CW        (CW)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwr_ok_i    (pwr_ok_i),
        .hw_req_i    (hw_req_i),
        .sw_store_i  (sw_store_i),
        .sw_recall_i (sw_recall_i),
        .as_en_i     (as_en_i),
        .as_dis_i    (as_dis_i),
        .dirty_i     (dirty),
        .tmr_zero_i  (tmr_zero),
        .tmr_ld_o    (tmr_ld),
        .tmr_val_o   (tmr_val),
        .fin_o       (fin),
        .busy_o      (busy_o),
        .inhibit_o   (inhibit_o),
        .rd_ok_o     (rd_ok),
        .wr_ok_o     (wr_ok),
        .save_o      (save_o),
        .clear_o     (clear_o),
        .load_o      (load_o)
    );
endmodule

// File: rtl/nv_xfer_seq_chk.sv
module nv_xfer_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic pwr_ok_i,
    input logic hw_req_i,
    input logic busy_o,
    input logic inhibit_o,
    input logic rd_pass_o,
    input logic wr_pass_o,
    input logic save_o,
    input logic clear_o,
    input logic load_o
);
    a_r12_busy_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !wr_pass_o);

    a_r9_low_supply_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok_i |-> (!wr_pass_o && !rd_pass_o));

    a_r12_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({save_o, clear_o, load_o}));

    a_r7_clear_then_load: assert property (@(posedge clk) disable iff (!rst_n)
        clear_o |=> load_o);

    a_r2_save_stays_busy: assert property (@(posedge clk) disable iff (!rst_n)
        save_o |=> busy_o);

    a_r4_hold_until_release: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit_o && !busy_o && pwr_ok_i && hw_req_i) |=> inhibit_o);
endmodule

bind nv_xfer_seq nv_xfer_seq_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_ok_i  (pwr_ok_i),
    .hw_req_i  (hw_req_i),
    .busy_o    (busy_o),
    .inhibit_o (inhibit_o),
    .rd_pass_o (rd_pass_o),
    .wr_pass_o (wr_pass_o),
    .save_o    (save_o),
    .clear_o   (clear_o),
    .load_o    (load_o)
);

// File: tb/nv_xfer_seq_tb_top.sv
module nv_xfer_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TD = 3, TS = 5, TR = 4, THR = 6;
    localparam int HOLD = 15, WIN = 40;
    // kind: 0 sw save, 1 sw load, 2 hw request, 3 supply loss, 4 both 2 and 3
    // fields: kind, dirty, busy, save, clear, load, inhibit
    localparam int NV = 7;
    localparam int VEC [NV][7] = '{
        '{0, 0, TD+1+TS,          1, 0, 0, 1+TS},
        '{0, 1, TD+1+TS,          1, 0, 0, 1+TS},
        '{1, 1, TD+2+TR,          0, 1, 1, 2+TR},
        '{2, 1, TD+1+TS,          1, 0, 0, HOLD-TD},
        '{2, 0, 0,                0, 0, 0, HOLD},
        '{3, 1, TD+1+TS+2+THR,    1, 1, 1, HOLD-TD+2+THR},
        '{3, 0, 2+THR,            0, 1, 1, HOLD+2+THR}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic acc_rd = 0, acc_wr = 0, hw_req = 0, pwr_ok = 1;
    logic sw_store = 0, sw_recall = 0, as_en = 0, as_dis = 0;
    logic rd_pass, wr_pass, busy, inhibit, save, clear, load;
    int nchk = 0, nfail = 0;
    int c_busy, c_save, c_clr, c_ld, c_inh, save_idx;

    always #(CLK_PERIOD/2) clk = ~clk;

    nv_xfer_seq #(.T_DELAY(TD), .T_STORE(TS), .T_RECALL(TR), .T_HRECALL(THR)) dut_i (
        .clk(clk), .rst_n(rst_n), .acc_rd_i(acc_rd), .acc_wr_i(acc_wr),
        .hw_req_i(hw_req), .pwr_ok_i(pwr_ok), .sw_store_i(sw_store),
        .sw_recall_i(sw_recall), .as_en_i(as_en), .as_dis_i(as_dis),
        .rd_pass_o(rd_pass), .wr_pass_o(wr_pass), .busy_o(busy),
        .inhibit_o(inhibit), .save_o(save), .clear_o(clear), .load_o(load)
    );

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_write();
        @(negedge clk); acc_wr = 1;
        #1 chk("R6 write accepted in idle", int'(wr_pass), 1);
        @(negedge clk); acc_wr = 0;
    endtask

    task automatic pulse_cmd(input int which);
        @(negedge clk);
        if (which == 0) as_dis = 1; else as_en = 1;
        @(negedge clk); as_dis = 0; as_en = 0;
    endtask

    task automatic run_scn(input int kind, input int dirty);
        c_busy = 0; c_save = 0; c_clr = 0; c_ld = 0; c_inh = 0; save_idx = -1;
        if (dirty != 0) do_write();
        @(negedge clk);
        case (kind)
            0: sw_store = 1;
            1: sw_recall = 1;
            2: hw_req = 1;
            3: pwr_ok = 0;
            default: begin hw_req = 1; pwr_ok = 0; end
        endcase
        for (int i = 0; i < WIN; i++) begin
            @(negedge clk);
            c_busy += int'(busy); c_save += int'(save); c_clr += int'(clear);
            c_ld += int'(load); c_inh += int'(inhibit);
            if (save && save_idx < 0) save_idx = i;
            sw_store = 0; sw_recall = 0;
            if (i == HOLD-1) begin hw_req = 0; pwr_ok = 1; end
        end
    endtask

    function automatic string tag_of(input int kind, input int dirty);
        case (kind)
            0: return "R2 software save";
            1: return "R7 software load";
            2: return (dirty != 0) ? "R4 hw request dirty" : "R5 hw request clean";
            default: return (dirty != 0) ? "R8 supply loss dirty" : "R9 supply loss clean";
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 inhibit", int'(inhibit), 0);
        chk("R1 strobes", int'({save, clear, load}), 0);
        acc_wr = 1;
        #1 chk("R1 write passes", int'(wr_pass), 1);
        @(negedge clk); acc_wr = 0;
        repeat (2) @(negedge clk);

        // vector table
        for (int v = 0; v < NV; v++) begin
            run_scn(VEC[v][0], VEC[v][1]);
            chk({tag_of(VEC[v][0], VEC[v][1]), " busy"},    c_busy, VEC[v][2]);
            chk({tag_of(VEC[v][0], VEC[v][1]), " save"},    c_save, VEC[v][3]);
            chk({tag_of(VEC[v][0], VEC[v][1]), " clear"},   c_clr,  VEC[v][4]);
            chk({tag_of(VEC[v][0], VEC[v][1]), " load"},    c_ld,   VEC[v][5]);
            chk({tag_of(VEC[v][0], VEC[v][1]), " inhibit"}, c_inh,  VEC[v][6]);
        end

        // R2 strobe timing, R3 grace access, R12 command ignored while busy
        @(negedge clk); sw_store = 1;
        c_clr = 0; save_idx = -1;
        for (int i = 0; i < WIN; i++) begin
            @(negedge clk);
            sw_store = 0; sw_recall = 0; acc_rd = 0; acc_wr = 0;
            if (save && save_idx < 0) save_idx = i;
            c_clr += int'(clear);
            if (i == 0) begin
                acc_rd = 1; acc_wr = 1;
                #1;
                chk("R3 grace read passes", int'(rd_pass), 1);
                chk("R3 grace write refused", int'(wr_pass), 0);
                chk("R3 grace busy", int'(busy), 1);
                chk("R3 grace not inhibited", int'(inhibit), 0);
            end
            if (i == TD+1) begin
                sw_recall = 1; acc_wr = 1;
                #1 chk("R12 write refused while busy", int'(wr_pass), 0);
            end
        end
        chk("R2 save strobe cycle", save_idx, TD);
        chk("R12 load command ignored while busy", c_clr, 0);

        // R6: a load clears the dirty flag, so a later hw request does not save
        do_write();
        run_scn(1, 0);
        run_scn(2, 0);
        chk("R6 dirty cleared by load", c_save, 0);

        // R10: disable automatic save, dirty supply loss must not save
        pulse_cmd(0);
        run_scn(3, 1);
        chk("R10 disabled no save", c_save, 0);
        chk("R8 disabled supply loss busy", c_busy, 2+THR);
        pulse_cmd(1);
        run_scn(3, 1);
        chk("R10 re-enabled save", c_save, 1);

        // R11 merge of supply loss and hw request
        run_scn(4, 1);
        chk("R11 single save", c_save, 1);
        chk("R11 busy total", c_busy, TD+1+TS+2+THR);

        // R9 access blocked while supply low
        @(negedge clk); pwr_ok = 0;
        repeat (3) @(negedge clk);
        acc_rd = 1; acc_wr = 1;
        #1;
        chk("R9 read blocked low supply", int'(rd_pass), 0);
        chk("R9 write blocked low supply", int'(wr_pass), 0);
        chk("R9 inhibited low supply", int'(inhibit), 1);
        @(negedge clk); acc_rd = 0; acc_wr = 0; pwr_ok = 1;
        repeat (20) @(negedge clk);
        chk("R9 back to idle", int'(inhibit), 0);

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule